// File: doc/BRIEF.md
# Range-Mode-Aware Chirp Sequencer

This block steps a radar transmitter through the chirps of one frame. While it is idle it waits for a start request. It then issues a long-chirp phase, a short-chirp phase, or only the short phase. It counts each chirp as the waveform side signals its end with a completion pulse. The frame finishes in a done state, which lasts until the start request is dropped.

The host picks the operating range with a command write. The block accepts an opcode byte, a data byte and a write strobe. Only one opcode updates the stored range mode, and any data value that is not a legal code is stored as the short-range default. In short-range mode the sequencer goes straight from idle to short chirps and never issues a long one. In long-range mode it runs half the frame as long chirps and the other half as short chirps. The range mode is consulted only when a frame starts, so a host write during a frame takes effect on the next frame.

Top module: `chirp_seq_top`

## Requirements
- R1: After reset the chirp type is none (2'b00), both active flags and done are low, the count is 0, and the stored range mode is short-range.
- R2: A write with opcode 0x20 and data 0x01 selects long-range mode, and data 0x00 selects short-range mode. Writes with any other opcode leave the mode unchanged.
- R3: A write with opcode 0x20 and any data other than 0x00 or 0x01 (including low codes 2'b10 and 2'b11) is stored as short-range mode.
- R4: A start in idle under short-range mode shows a short chirp on the next cycle. No long chirp is issued in that frame.
- R5: In short-range mode the frame enters done after CHIRP_MAX completion pulses, and the count then reads CHIRP_MAX.
- R6: A start in idle under long-range mode shows a long chirp on the next cycle. After CHIRP_MAX/2 completion pulses the type switches to short.
- R7: In long-range mode, done is entered after CHIRP_MAX/2 further pulses, for CHIRP_MAX chirps in total.
- R8: Each completion pulse during an active chirp adds one to the count. Pulses in idle or in done have no effect. The count is cleared when a frame starts.
- R9: A range-mode write during a frame does not change that frame's sequence. It applies to the next frame.
- R10: Done holds while start stays high. One cycle after start goes low, the block is back in idle.
- R11: The chirp type encodes none as 2'b00, long as 2'b01 and short as 2'b10. The long-active, short-active and done outputs are never high two at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start request, held for the frame |
| cmd_wr_i | input | 1 | Host command write strobe |
| cmd_op_i | input | 8 | Host command opcode |
| cmd_data_i | input | 8 | Host command data |
| chirp_end_i | input | 1 | One pulse per completed chirp |
| chirp_kind_o | output | 2 | Current chirp type |
| long_active_o | output | 1 | Long chirp in progress |
| short_active_o | output | 1 | Short chirp in progress |
| chirp_cnt_o | output | 4 | Chirps completed in this frame |
| frame_done_o | output | 1 | Frame finished |

## Verification
The hardest case to reach is a host write that lands in the middle of a frame. Its effect stays hidden until the following frame starts, and the current frame must also show that it was not disturbed. The stimulus starts a short-range frame and writes long-range mode after a few chirps. It then drives the frame to done at the short-range count, releases start, and starts again to show the first chirp is long. The clamp is reached through its behaviour only: a legal long-range write followed by a reserved code must produce a short first chirp.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LONG  = 2'd1,
    SEQ_SHORT = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_LONG  = 2'b01,
    KIND_SHORT = 2'b10
  } chirp_kind_e;

  // Stored range codes; only bit 0 can differ between legal values.
  localparam logic [1:0] RANGE_NEAR = 2'b00;
  localparam logic [1:0] RANGE_FAR  = 2'b01;

endpackage

// File: rtl/chirp_rst_sync.sv
module chirp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/chirp_mode_reg.sv
module chirp_mode_reg
  import chirp_seq_pkg::*;
#(
  parameter int          OP_W     = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  OP_RANGE = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [1:0]        mode_o
);
  logic       wr_en;
  logic [1:0] mode_d;
  logic [1:0] mode_q;

  assign wr_en = wr_i && (op_i == OP_W'(OP_RANGE));

  // Clamp at write time: anything but the far-range code lands on near.
  always_comb begin
    if (data_i == DATA_W'(RANGE_FAR)) mode_d = RANGE_FAR;
    else                              mode_d = RANGE_NEAR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= RANGE_NEAR;
    else if (wr_en) mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/chirp_counter.sv
module chirp_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/chirp_seq_fsm.sv
module chirp_seq_fsm
  import chirp_seq_pkg::*;
#(
  parameter int CHIRP_MAX = 8,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             chirp_end_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output seq_state_e       state_o,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o
);
  localparam int              HALF      = CHIRP_MAX / 2;
  localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] LAST_ALL  = CNT_W'(CHIRP_MAX - 1);

  seq_state_e state_q, state_d;
  logic       chirping;

  assign chirping  = (state_q == SEQ_LONG) || (state_q == SEQ_SHORT);
  assign cnt_inc_o = chirping && chirp_end_i;
  assign cnt_clr_o = (state_q == SEQ_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) state_d = (mode_i == RANGE_FAR) ? SEQ_LONG : SEQ_SHORT;
      end
      SEQ_LONG: begin
        if (chirp_end_i && cnt_i == LAST_LONG) state_d = SEQ_SHORT;
      end
      SEQ_SHORT: begin
        if (chirp_end_i && cnt_i == LAST_ALL) state_d = SEQ_DONE;
      end
      SEQ_DONE: begin
        if (!start_i) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/chirp_seq_top.sv
module chirp_seq_top
  import chirp_seq_pkg::*;
#(
  parameter int         CHIRP_MAX = 8,
  parameter int         OP_W      = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] OP_RANGE  = 8'h20,
  localparam int        CNT_W     = $clog2(CHIRP_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmd_wr_i,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              chirp_end_i,
  output logic [1:0]        chirp_kind_o,
  output logic              long_active_o,
  output logic              short_active_o,
  output logic [CNT_W-1:0]  chirp_cnt_o,
  output logic              frame_done_o
);
  logic       rst_n_sync;
  logic [1:0] host_mode;
  logic       cnt_clr, cnt_inc;
  seq_state_e seq_state;

  chirp_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n_sync)
  );

  chirp_mode_reg #(.OP_W(OP_W), .DATA_W(DATA_W), .OP_RANGE(OP_RANGE)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_n_sync), .wr_i(cmd_wr_i),
    .op_i(cmd_op_i), .data_i(cmd_data_i), .mode_o(host_mode)
  );

  chirp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n_sync), .clr_i(cnt_clr),
    .inc_i(cnt_inc), .cnt_o(chirp_cnt_o)
  );

  chirp_seq_fsm #(.CHIRP_MAX(CHIRP_MAX), .CNT_W(CNT_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_n_sync), .start_i(start_i),
    .chirp_end_i(chirp_end_i), .mode_i(host_mode), .cnt_i(chirp_cnt_o),
    .state_o(seq_state), .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc)
  );

  always_comb begin
    long_active_o  = (seq_state == SEQ_LONG);
    short_active_o = (seq_state == SEQ_SHORT);
    frame_done_o   = (seq_state == SEQ_DONE);
    unique case (seq_state)
      SEQ_LONG:  chirp_kind_o = KIND_LONG;
      SEQ_SHORT: chirp_kind_o = KIND_SHORT;
      default:   chirp_kind_o = KIND_NONE;
    endcase
  end
endmodule

// File: rtl/chirp_seq_checker.sv
module chirp_seq_checker #(
  parameter int         CHIRP_MAX = 8,
  parameter int         OP_W      = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] OP_RANGE  = 8'h20,
  parameter int         CNT_W     = 4
) (
  input logic              clk_i,
  input logic              rst_n_sync,
  input logic              start_i,
  input logic              cmd_wr_i,
  input logic [OP_W-1:0]   cmd_op_i,
  input logic [DATA_W-1:0] cmd_data_i,
  input logic              chirp_end_i,
  input logic [1:0]        chirp_kind_o,
  input logic              long_active_o,
  input logic              short_active_o,
  input logic [CNT_W-1:0]  chirp_cnt_o,
  input logic              frame_done_o,
  input logic [1:0]        host_mode
);
  logic idle, range_wr, active;
  assign idle     = !long_active_o && !short_active_o && !frame_done_o;
  assign active   = long_active_o || short_active_o;
  assign range_wr = cmd_wr_i && (cmd_op_i == OP_W'(OP_RANGE));

  assert_far_write_R2: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    range_wr && cmd_data_i == DATA_W'(1) |=> host_mode == 2'b01);
  assert_other_op_R2: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    cmd_wr_i && cmd_op_i != OP_W'(OP_RANGE) |=> $stable(host_mode));
  assert_reserved_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    range_wr && cmd_data_i != DATA_W'(1) |=> host_mode == 2'b00);
  assert_near_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    idle && start_i && host_mode == 2'b00 |=> short_active_o);
  assert_done_count_R5: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    frame_done_o |-> chirp_cnt_o == CNT_W'(CHIRP_MAX));
  assert_far_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    idle && start_i && host_mode == 2'b01 |=> long_active_o);
  assert_long_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    long_active_o |-> chirp_cnt_o < CNT_W'(CHIRP_MAX / 2));
  assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    active && chirp_end_i |=> chirp_cnt_o == CNT_W'($past(chirp_cnt_o) + 1'b1));
  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    frame_done_o |=> $stable(chirp_cnt_o));
  assert_done_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    frame_done_o && !start_i |=> idle);
  assert_one_kind_R11: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    $onehot0({long_active_o, short_active_o, frame_done_o}) && chirp_kind_o != 2'b11);
endmodule

bind chirp_seq_top chirp_seq_checker #(
  .CHIRP_MAX(CHIRP_MAX), .OP_W(OP_W), .DATA_W(DATA_W),
  .OP_RANGE(OP_RANGE), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/chirp_seq_top_tb_top.sv
module chirp_seq_top_tb_top;
  localparam int CM = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni, start_i, cmd_wr_i, chirp_end_i;
  logic [7:0] cmd_op_i, cmd_data_i;
  logic [1:0] chirp_kind_o;
  logic       long_active_o, short_active_o, frame_done_o;
  logic [3:0] chirp_cnt_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  chirp_seq_top dut_i (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [7:0] data;
    logic [7:0] pulses;
    logic [1:0] kind;
    logic [3:0] cnt;
    logic       done;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'd0, 2'b10, 4'd0, 1'b0, 4'd4},  // R4 near: short first
    '{8'h00, 8'd3, 2'b10, 4'd3, 1'b0, 4'd8},  // R8 counting
    '{8'h00, 8'd8, 2'b00, 4'd8, 1'b1, 4'd5},  // R5 near done
    '{8'h01, 8'd0, 2'b01, 4'd0, 1'b0, 4'd6},  // R6 far: long first
    '{8'h01, 8'd3, 2'b01, 4'd3, 1'b0, 4'd6},  // R6 still long
    '{8'h01, 8'd4, 2'b10, 4'd4, 1'b0, 4'd6},  // R6 switch to short
    '{8'h01, 8'd7, 2'b10, 4'd7, 1'b0, 4'd7},  // R7
    '{8'h01, 8'd8, 2'b00, 4'd8, 1'b1, 4'd7},  // R7 far done
    '{8'h02, 8'd0, 2'b10, 4'd0, 1'b0, 4'd3},  // R3 code 10
    '{8'h03, 8'd0, 2'b10, 4'd0, 1'b0, 4'd3},  // R3 code 11
    '{8'h03, 8'd8, 2'b00, 4'd8, 1'b1, 4'd3}   // R3 clamped frame
  };

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    start_i = 0; cmd_wr_i = 0; cmd_op_i = 0; cmd_data_i = 0; chirp_end_i = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic host_write(input logic [7:0] op, input logic [7:0] data);
    cmd_wr_i = 1; cmd_op_i = op; cmd_data_i = data;
    @(negedge clk_i);
    cmd_wr_i = 0;
    @(negedge clk_i);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      chirp_end_i = 1;
      @(negedge clk_i);
      chirp_end_i = 0;
      @(negedge clk_i);
    end
  endtask

  task automatic begin_frame();
    start_i = 1;
    @(negedge clk_i);
  endtask

  initial begin
    // R1 reset state
    do_reset();
    check("R1", "kind", chirp_kind_o, 0);
    check("R1", "flags", {long_active_o, short_active_o, frame_done_o}, 0);
    check("R1", "count", chirp_cnt_o, 0);
    begin_frame();
    check("R1", "default mode gives short", chirp_kind_o, 2);

    for (int v = 0; v < NV; v++) begin
      string r;
      do_reset();
      host_write(8'h20, VECS[v].data);
      begin_frame();
      pulses(int'(VECS[v].pulses));
      r = $sformatf("R%0d vec%0d", VECS[v].req, v);
      check(r, "kind", chirp_kind_o, int'(VECS[v].kind));
      check(r, "count", chirp_cnt_o, int'(VECS[v].cnt));
      check(r, "done", frame_done_o, int'(VECS[v].done));
      check("R11", "flags vs kind", {long_active_o, short_active_o},
            {chirp_kind_o[0], chirp_kind_o[1]});
    end

    // R2 other opcode ignored
    do_reset();
    host_write(8'h21, 8'h01);
    begin_frame();
    check("R2", "other opcode kind", chirp_kind_o, 2);

    // R3 far then reserved code clamps back to near
    do_reset();
    host_write(8'h20, 8'h01);
    host_write(8'h20, 8'h02);
    begin_frame();
    check("R3", "clamped kind", chirp_kind_o, 2);

    // R8 pulses in idle ignored
    do_reset();
    pulses(2);
    check("R8", "idle count", chirp_cnt_o, 0);
    check("R8", "idle kind", chirp_kind_o, 0);

    // R9 mid-frame write, R10 done hold and exit
    begin_frame();
    pulses(3);
    host_write(8'h20, 8'h01);
    check("R9", "kind after mid write", chirp_kind_o, 2);
    pulses(5);
    check("R9", "near frame done", frame_done_o, 1);
    pulses(2);
    check("R8", "done count hold", chirp_cnt_o, 8);
    repeat (3) @(negedge clk_i);
    check("R10", "done held", frame_done_o, 1);
    start_i = 0;
    @(negedge clk_i);
    check("R10", "back to idle", {frame_done_o, chirp_kind_o}, 0);
    begin_frame();
    check("R9", "next frame long", chirp_kind_o, 1);
    check("R8", "count cleared", chirp_cnt_o, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule